// File: doc/BRIEF.md
# Branch Redirect and Flush Controller

This block steers instruction fetch for a fourteen-stage in-order pipeline. In that pipeline a branch or jump target is ready early, while the condition of a conditional branch is ready late. The controller keeps a valid bit and a branch/jump tag for every in-flight slot. It takes the target address while the instruction sits in stage 3 and the resolved condition while the instruction sits in stage 10. From these it decides, each cycle, whether the next fetch address is sequential, held, or redirected, and which stages hold wrong-path work that must be squashed.

Three policies are selectable. Freeze holds fetch while a conditional branch is unresolved. Not-taken keeps fetching sequentially and repairs the path when a branch turns out taken. Predictor-assisted follows an external predicted-taken bit, but only once the branch's target is latched. A late repair always beats an early redirect issued in the same cycle, because the early one belongs to a younger, doomed instruction.

Top module: `branch_redirect_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every slot is empty: `pc_sel` is 0 (sequential), `kill_mask` is 0 and `fetch_stall` is 0.
- R2: A jump (kind 2) offered to fetch in cycle t redirects in cycle t+3 to the target presented on `tgt_in` in cycle t+2, with `kill_mask` = 0x0007 (bit k-1 stands for stage k). This holds in every mode.
- R3: In mode 2 (predictor), a conditional branch (kind 1) with `f_pred` = 1 redirects to its target in cycle t+3, never earlier, with `kill_mask` = 0x0007.
- R4: A conditional branch whose condition (sampled on `cond_in` in cycle t+9) differs from its effective prediction redirects in cycle t+10, with `kill_mask` = 0x03FF. The redirect address is the target when the branch is taken and the branch address plus 4 when it is not.
- R5: In mode 1 (not-taken) the effective prediction is always not-taken and `f_pred` has no effect. A branch that resolves not-taken produces no redirect and no kill.
- R6: In mode 0 (freeze), `fetch_stall` is 1 and `pc_sel` is 1 (hold) in cycles t+1 to t+10 after a conditional branch is fetched. In cycle t+10 the controller redirects to the resolved address with `kill_mask` = 0x03FF. An instruction offered while the stall is high is dropped.
- R7: When a late repair and an early redirect fall in the same cycle, the late repair's address and mask are output.
- R8: A squashed slot never redirects. This covers instructions in stages 1 to 3 during an early redirect and stages 1 to 10 during a late repair.
- R9: A correctly predicted branch in mode 2 causes no late redirect and no kill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Policy: 0 freeze, 1 not-taken, 2 predictor, 3 acts as not-taken; change only while the pipeline is empty |
| f_valid | input | 1 | An instruction is being fetched this cycle (stage 1) |
| f_kind | input | 2 | Decode tag of that instruction: 0 plain, 1 conditional branch, 2 jump, 3 plain |
| f_pred | input | 1 | Predicted-taken bit delivered with the fetch |
| f_pc | input | ADDR_W | Address of the fetched instruction |
| tgt_in | input | ADDR_W | Target computed for the instruction now in stage 3 |
| cond_in | input | 1 | Condition computed for the instruction now in stage 10 (1 = taken) |
| pc_sel | output | 2 | Next-PC choice: 0 sequential, 1 hold, 2 redirect |
| redirect_target | output | ADDR_W | Next fetch address when `pc_sel` is 2 |
| fetch_stall | output | 1 | Fetch is held by the freeze policy |
| kill_mask | output | NSTG | Bit k-1 squashes the instruction in stage k this cycle |

## Verification
A corrupted valid bit or tag in a slot shows up at the ports three or ten cycles after fetch. It appears as a redirect in a cycle where none is due, a missing redirect, or a stray hold in freeze mode. A wrongly latched target or condition shows up as a wrong `redirect_target` in the one cycle the redirect occurs. A kill that fails to clear a slot surfaces later, when that wrong-path instruction reaches stage 4 or stage 11 and redirects. The scoreboard therefore checks every cycle: expected redirects by exact cycle, address and mask, and all other cycles for the absence of any redirect, kill or unexpected stall.

// File: rtl/brc_pkg.sv
// Shared types for the branch redirect controller.
// Assumes: one instruction per stage per cycle, in-order flow.
package brc_pkg;

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_COND  = 2'd1,
        K_JUMP  = 2'd2,
        K_OTHER = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        M_FREEZE  = 2'd0,
        M_NTAKEN  = 2'd1,
        M_PREDICT = 2'd2,
        M_SPARE   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SEL_SEQ   = 2'd0,
        SEL_HOLD  = 2'd1,
        SEL_REDIR = 2'd2,
        SEL_SPARE = 2'd3
    } sel_e;

    // Per-slot control record carried down the pipeline.
    typedef struct packed {
        logic  valid;
        kind_e kind;
        logic  pred;
        logic  taken;
    } slot_t;

endpackage

// File: rtl/brc_stage_track.sv
// Slot tracker: shifts a control record, address and target down the
// stages every cycle, dropping squashed slots. It latches the target as
// a slot leaves the address stage and the condition as a slot leaves
// the condition stage.
// Assumes: the pipeline never stalls internally; bubbles enter at fetch.
module brc_stage_track
    import brc_pkg::*;
#(
    parameter int unsigned NSTG     = 14,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned ADDR_STG = 3,
    parameter int unsigned COND_STG = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_take,
    input  kind_e             f_kind,
    input  logic              f_pred,
    input  logic [ADDR_W-1:0] f_pc,
    input  logic [ADDR_W-1:0] tgt_in,
    input  logic              cond_in,
    input  logic [NSTG-2:0]   kill,
    output logic              early_valid,
    output kind_e             early_kind,
    output logic              early_pred,
    output logic [ADDR_W-1:0] early_tgt,
    output slot_t             late_slot,
    output logic [ADDR_W-1:0] late_pc,
    output logic [ADDR_W-1:0] late_tgt,
    output logic [COND_STG-1:0] cond_live,
    output logic              s2_valid
);
    localparam int unsigned EARLY = ADDR_STG + 1;
    localparam int unsigned LATE  = COND_STG + 1;

    slot_t             stg   [1:NSTG];
    logic [ADDR_W-1:0] pc_v  [1:NSTG];
    logic [ADDR_W-1:0] tgt_v [1:NSTG];

    slot_t             q_stg [2:NSTG];
    logic [ADDR_W-1:0] q_pc  [2:NSTG];
    logic [ADDR_W-1:0] q_tgt [2:NSTG];
    logic [NSTG:2]     vld;

    // Stage 1 is the instruction on the fetch inputs this cycle.
    always_comb begin
        stg[1]   = '{valid: fetch_take, kind: f_kind, pred: f_pred, taken: 1'b0};
        pc_v[1]  = f_pc;
        tgt_v[1] = '0;
    end

    // Stage views for the registered stages.
    genvar g;
    generate
        for (g = 2; g <= NSTG; g++) begin : g_view
            assign stg[g]   = q_stg[g];
            assign pc_v[g]  = q_pc[g];
            assign tgt_v[g] = q_tgt[g];
            assign vld[g]   = q_stg[g].valid;
        end
        for (g = 2; g <= COND_STG + 1; g++) begin : g_live
            assign cond_live[g-2] = stg[g].valid && (stg[g].kind == K_COND);
        end
    endgenerate

    // Advance every slot one stage, applying kills and resolution latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 2; k <= NSTG; k++) begin
                q_stg[k] <= '0;
                q_pc[k]  <= '0;
                q_tgt[k] <= '0;
            end
        end else begin
            for (int k = 2; k <= NSTG; k++) begin
                q_stg[k].valid <= stg[k-1].valid && !kill[k-2];
                q_stg[k].kind  <= stg[k-1].kind;
                q_stg[k].pred  <= stg[k-1].pred;
                q_stg[k].taken <= (k - 1 == COND_STG) ? cond_in : stg[k-1].taken;
                q_pc[k]        <= pc_v[k-1];
                q_tgt[k]       <= (k - 1 == ADDR_STG) ? tgt_in : tgt_v[k-1];
            end
        end
    end

    // Export the two decision points and the fetch-side entry flag.
    always_comb begin
        early_valid = stg[EARLY].valid;
        early_kind  = stg[EARLY].kind;
        early_pred  = stg[EARLY].pred;
        early_tgt   = tgt_v[EARLY];
        late_slot   = stg[LATE];
        late_pc     = pc_v[LATE];
        late_tgt    = tgt_v[LATE];
        s2_valid    = stg[2].valid;
    end

    // R1: a reset cycle leaves every registered slot empty.
    p_reset_clears_r1: assert property (@(posedge clk) !rst_n |=> (vld == '0));

endmodule

// File: rtl/brc_freeze_hold.sv
// Freeze policy: holds fetch while any conditional branch is in flight
// between stage 2 and the stage where its condition is usable.
// Assumes: the mode is only changed while the pipeline is empty.
module brc_freeze_hold
    import brc_pkg::*;
#(
    parameter int unsigned LIVE_W = 10
) (
    input  mode_e             mode,
    input  logic [LIVE_W-1:0] cond_live,
    output logic              hold
);
    // Hold whenever freeze is selected and a branch is unresolved.
    always_comb hold = (mode == M_FREEZE) && (|cond_live);

endmodule

// File: rtl/brc_resolve.sv
// Redirect arbiter: compares the slot at the early point (target just
// latched) and the slot at the late point (condition just latched) and
// chooses the next-PC source, its address and the squash mask. The late
// repair is older and always wins.
// Assumes: slot records come from brc_stage_track.
module brc_resolve
    import brc_pkg::*;
#(
    parameter int unsigned NSTG     = 14,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned ADDR_STG = 3,
    parameter int unsigned COND_STG = 10,
    parameter int unsigned STEP     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic              early_valid,
    input  kind_e             early_kind,
    input  logic              early_pred,
    input  logic [ADDR_W-1:0] early_tgt,
    input  slot_t             late_slot,
    input  logic [ADDR_W-1:0] late_pc,
    input  logic [ADDR_W-1:0] late_tgt,
    input  logic              hold,
    output sel_e              sel,
    output logic [ADDR_W-1:0] dest,
    output logic [NSTG-1:0]   kill
);
    localparam logic [NSTG-1:0] EARLY_KILL = NSTG'((64'd1 << ADDR_STG) - 64'd1);
    localparam logic [NSTG-1:0] LATE_KILL  = NSTG'((64'd1 << COND_STG) - 64'd1);

    logic early_act;
    logic late_act;
    logic late_pred;
    logic [ADDR_W-1:0] late_dest;

    // Early point: jumps always, predicted-taken branches in predictor mode.
    always_comb begin
        early_act = early_valid &&
                    ((early_kind == K_JUMP) ||
                     ((early_kind == K_COND) && (mode == M_PREDICT) && early_pred));
    end

    // Late point: repair when the outcome differs from what fetch assumed.
    always_comb begin
        late_pred = (mode == M_PREDICT) && late_slot.pred;
        late_act  = late_slot.valid && (late_slot.kind == K_COND) &&
                    ((mode == M_FREEZE) || (late_slot.taken != late_pred));
        late_dest = late_slot.taken ? late_tgt : (late_pc + ADDR_W'(STEP));
    end

    // Pick the oldest action; hold only when nothing redirects.
    always_comb begin
        sel  = SEL_SEQ;
        dest = '0;
        kill = '0;
        if (late_act) begin
            sel  = SEL_REDIR;
            dest = late_dest;
            kill = LATE_KILL;
        end else if (early_act) begin
            sel  = SEL_REDIR;
            dest = early_tgt;
            kill = EARLY_KILL;
        end else if (hold) begin
            sel  = SEL_HOLD;
        end
    end

    // R8: an early redirect squashes the slot that would redirect next.
    p_no_repeat_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_REDIR && kill == EARLY_KILL) |=> !(sel == SEL_REDIR && kill == EARLY_KILL));

endmodule

// File: rtl/branch_redirect_ctrl.sv
// Top of the fetch redirect and flush controller for a deep in-order
// pipeline: targets are usable after ADDR_STG, conditions after COND_STG.
// Assumes: fetch supplies one decoded tag per cycle; the external target
// adder and condition logic drive tgt_in / cond_in for stages ADDR_STG
// and COND_STG respectively.
module branch_redirect_ctrl
    import brc_pkg::*;
#(
    parameter int unsigned NSTG     = 14,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned ADDR_STG = 3,
    parameter int unsigned COND_STG = 10,
    parameter int unsigned STEP     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              f_valid,
    input  logic [1:0]        f_kind,
    input  logic              f_pred,
    input  logic [ADDR_W-1:0] f_pc,
    input  logic [ADDR_W-1:0] tgt_in,
    input  logic              cond_in,
    output logic [1:0]        pc_sel,
    output logic [ADDR_W-1:0] redirect_target,
    output logic              fetch_stall,
    output logic [NSTG-1:0]   kill_mask
);
    localparam logic [NSTG-1:0] EARLY_KILL = NSTG'((64'd1 << ADDR_STG) - 64'd1);
    localparam logic [NSTG-1:0] LATE_KILL  = NSTG'((64'd1 << COND_STG) - 64'd1);

    mode_e             mode_q;
    logic              fetch_take;
    logic              hold;
    logic              early_valid;
    kind_e             early_kind;
    logic              early_pred;
    logic [ADDR_W-1:0] early_tgt;
    slot_t             late_slot;
    logic [ADDR_W-1:0] late_pc;
    logic [ADDR_W-1:0] late_tgt;
    logic [COND_STG-1:0] cond_live;
    logic              s2_valid;
    sel_e              sel;

    // Decode the mode and gate fetch entry by the freeze hold.
    always_comb begin
        mode_q     = mode_e'(mode);
        fetch_take = f_valid && !hold;
    end

    brc_stage_track #(
        .NSTG(NSTG), .ADDR_W(ADDR_W), .ADDR_STG(ADDR_STG), .COND_STG(COND_STG)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .fetch_take(fetch_take),
        .f_kind(kind_e'(f_kind)), .f_pred(f_pred), .f_pc(f_pc),
        .tgt_in(tgt_in), .cond_in(cond_in), .kill(kill_mask[NSTG-2:0]),
        .early_valid(early_valid), .early_kind(early_kind), .early_pred(early_pred),
        .early_tgt(early_tgt), .late_slot(late_slot), .late_pc(late_pc),
        .late_tgt(late_tgt), .cond_live(cond_live), .s2_valid(s2_valid)
    );

    brc_freeze_hold #(.LIVE_W(COND_STG)) u_hold (
        .mode(mode_q), .cond_live(cond_live), .hold(hold)
    );

    brc_resolve #(
        .NSTG(NSTG), .ADDR_W(ADDR_W), .ADDR_STG(ADDR_STG),
        .COND_STG(COND_STG), .STEP(STEP)
    ) u_resolve (
        .clk(clk), .rst_n(rst_n), .mode(mode_q),
        .early_valid(early_valid), .early_kind(early_kind), .early_pred(early_pred),
        .early_tgt(early_tgt), .late_slot(late_slot), .late_pc(late_pc),
        .late_tgt(late_tgt), .hold(hold), .sel(sel), .dest(redirect_target),
        .kill(kill_mask)
    );

    // Drive the plain-typed outputs.
    always_comb begin
        pc_sel      = sel;
        fetch_stall = hold;
    end

    // R3: an early redirect uses the target presented one cycle before.
    p_early_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == 2'd2 && kill_mask == EARLY_KILL) |-> redirect_target == $past(tgt_in));

    // R4: after a late repair nothing is left in flight to redirect or hold.
    p_flush_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == 2'd2 && kill_mask == LATE_KILL) |=> (pc_sel != 2'd2 && !fetch_stall));

    // R6: a fetch offered during a stall never enters stage 2.
    p_stall_blocks_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> !s2_valid);

endmodule

// File: tb/branch_redirect_ctrl_bench.sv
module branch_redirect_ctrl_bench;
    localparam int NSTG = 14;
    localparam int AW   = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode;
    logic          f_valid;
    logic [1:0]    f_kind;
    logic          f_pred;
    logic [AW-1:0] f_pc;
    logic [AW-1:0] tgt_in;
    logic          cond_in;
    logic [1:0]    pc_sel;
    logic [AW-1:0] redirect_target;
    logic          fetch_stall;
    logic [NSTG-1:0] kill_mask;

    always #5 clk = ~clk;

    branch_redirect_ctrl u_branch_redirect_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .f_valid(f_valid), .f_kind(f_kind),
        .f_pred(f_pred), .f_pc(f_pc), .tgt_in(tgt_in), .cond_in(cond_in),
        .pc_sel(pc_sel), .redirect_target(redirect_target),
        .fetch_stall(fetch_stall), .kill_mask(kill_mask)
    );

    typedef struct {
        int            cyc;
        logic [1:0]    sel;
        logic [AW-1:0] dest;
        logic [NSTG-1:0] kill;
        string         req;
    } exp_t;

    exp_t          q[$];
    logic [AW-1:0] tgt_s[int];
    bit            cond_s[int];
    bit            stall_s[int];
    int            n_cmp = 0;
    int            n_bad = 0;
    int            cyc = 0;
    bit            mon_on = 0;
    string         idle_tag = "R8";
    string         late_tag = "R4";

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
        end
    endtask

    task automatic push(int c, logic [1:0] s, logic [AW-1:0] d, logic [NSTG-1:0] k, string r);
        exp_t e;
        e.cyc = c; e.sel = s; e.dest = d; e.kill = k; e.req = r;
        q.push_back(e);
    endtask

    // Driver: one cycle of fetch stimulus plus scheduled resolution inputs.
    task automatic step(bit v, logic [1:0] k, logic [AW-1:0] pc, bit pr);
        @(negedge clk);
        cyc++;
        f_valid = v; f_kind = k; f_pc = pc; f_pred = pr;
        tgt_in  = tgt_s.exists(cyc) ? tgt_s[cyc] : '0;
        cond_in = cond_s.exists(cyc) ? cond_s[cyc] : 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b1, 2'd0, 32'h40, 1'b0);
    endtask

    // Driver: fetch a branch/jump and push the outcomes the requirements imply.
    task automatic issue(logic [1:0] k, logic [AW-1:0] pc, bit pr,
                         logic [AW-1:0] tgt, bit tk, bit doomed);
        int t;
        bit ep;
        t = cyc + 1;
        tgt_s[t+2] = tgt;
        if (k == 2'd1) cond_s[t+9] = tk;
        if (!doomed) begin
            if (k == 2'd2) begin
                push(t+3, 2'd2, tgt, 14'h0007, "R2");
            end else if (mode == 2'd0) begin
                for (int i = 1; i <= 10; i++) stall_s[t+i] = 1'b1;
                push(t+10, 2'd2, tk ? tgt : pc + 32'd4, 14'h03FF, "R6");
            end else begin
                ep = (mode == 2'd2) && pr;
                if (ep) push(t+3, 2'd2, tgt, 14'h0007, "R3");
                if (tk != ep) push(t+10, 2'd2, tk ? tgt : pc + 32'd4, 14'h03FF, late_tag);
            end
        end
        step(1'b1, k, pc, pr);
    endtask

    // Monitor: pop and compare expected redirects; all other cycles stay quiet.
    always @(negedge clk) begin
        bit es;
        int hit;
        #2;
        if (mon_on) begin
            es  = stall_s.exists(cyc);
            hit = -1;
            chk(fetch_stall === es, "R6", "fetch_stall", fetch_stall, es);
            foreach (q[i]) if (hit < 0 && q[i].cyc == cyc) hit = i;
            if (hit >= 0) begin
                chk(pc_sel === q[hit].sel, q[hit].req, "pc_sel", pc_sel, q[hit].sel);
                chk(redirect_target === q[hit].dest, q[hit].req, "redirect_target",
                    redirect_target, q[hit].dest);
                chk(kill_mask === q[hit].kill, q[hit].req, "kill_mask", kill_mask, q[hit].kill);
                q.delete(hit);
            end else begin
                chk(pc_sel === (es ? 2'd1 : 2'd0), idle_tag, "pc_sel (no redirect due)",
                    pc_sel, es ? 2'd1 : 2'd0);
                chk(kill_mask === '0, idle_tag, "kill_mask (no redirect due)", kill_mask, 0);
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 2'd1; f_valid = 1'b0; f_kind = 2'd0; f_pred = 1'b0;
        f_pc = '0; tgt_in = '0; cond_in = 1'b0;
        repeat (4) step(1'b0, 2'd0, 32'h0, 1'b0);
        #2;
        // R1: reset state.
        chk(pc_sel === 2'd0, "R1", "pc_sel after reset", pc_sel, 0);
        chk(kill_mask === '0, "R1", "kill_mask after reset", kill_mask, 0);
        chk(fetch_stall === 1'b0, "R1", "fetch_stall after reset", fetch_stall, 0);
        rst_n  = 1'b1;
        mon_on = 1'b1;
        idle(3);

        // R2: jump in not-taken mode.
        idle_tag = "R8";
        issue(2'd2, 32'h100, 1'b0, 32'h800, 1'b0, 1'b0);
        idle(15);

        // R4 / R5: not-taken mode, taken repair, not-taken silence, pred ignored.
        idle_tag = "R5";
        issue(2'd1, 32'h200, 1'b0, 32'h900, 1'b1, 1'b0);
        idle(12);
        issue(2'd1, 32'h300, 1'b0, 32'hA00, 1'b0, 1'b0);
        idle(12);
        issue(2'd1, 32'h340, 1'b1, 32'hA40, 1'b0, 1'b0);
        idle(14);

        // R3 / R4 / R9: predictor mode, all four prediction/outcome pairs.
        mode = 2'd2;
        idle_tag = "R9";
        issue(2'd1, 32'h400, 1'b1, 32'hB00, 1'b1, 1'b0);
        idle(12);
        issue(2'd1, 32'h440, 1'b1, 32'hB40, 1'b0, 1'b0);
        idle(12);
        issue(2'd1, 32'h480, 1'b0, 32'hB80, 1'b1, 1'b0);
        idle(12);
        issue(2'd1, 32'h4C0, 1'b0, 32'hBC0, 1'b0, 1'b0);
        idle(14);

        // R8: slots squashed by an early redirect never redirect.
        mode = 2'd1;
        idle_tag = "R8";
        issue(2'd2, 32'h500, 1'b0, 32'hC00, 1'b0, 1'b0);
        issue(2'd2, 32'h504, 1'b0, 32'hC04, 1'b0, 1'b1);
        idle(1);
        issue(2'd2, 32'h50C, 1'b0, 32'hC0C, 1'b0, 1'b1);
        issue(2'd2, 32'h510, 1'b0, 32'hC10, 1'b0, 1'b0);
        idle(12);
        // R8: a jump in stage 3 during a late repair is squashed.
        issue(2'd1, 32'h600, 1'b0, 32'hD00, 1'b1, 1'b0);
        idle(7);
        issue(2'd2, 32'h620, 1'b0, 32'hD20, 1'b0, 1'b1);
        idle(14);

        // R7: late repair of an older branch beats a younger jump's early redirect.
        mode = 2'd2;
        late_tag = "R7";
        issue(2'd1, 32'h700, 1'b1, 32'hE00, 1'b0, 1'b0);
        idle(6);
        issue(2'd2, 32'h720, 1'b0, 32'hE20, 1'b0, 1'b1);
        idle(14);
        late_tag = "R4";

        // R6: freeze mode, taken and not-taken, dropped fetch, jump without hold.
        mode = 2'd0;
        idle_tag = "R6";
        issue(2'd1, 32'h800, 1'b0, 32'hF00, 1'b1, 1'b0);
        step(1'b0, 2'd0, 32'h0, 1'b0);
        step(1'b1, 2'd2, 32'h808, 1'b0);
        idle(13);
        issue(2'd1, 32'h840, 1'b0, 32'hF40, 1'b0, 1'b0);
        idle(13);
        issue(2'd2, 32'h880, 1'b0, 32'hF80, 1'b0, 1'b0);
        idle(12);

        mon_on = 1'b0;
        foreach (q[i]) chk(1'b0, q[i].req, "expected redirect never seen", q[i].cyc, 0);
        summary();
        $finish;
    end
endmodule